// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the byte-level protocol engine of a two-wire (I2C) serial EEPROM slave whose array holds between 128 and 2048 bytes, picked by a parameter. A bus-condition front end gives it single-cycle events: START, STOP, each bit sampled on the SCL rising edge (with its value) and each SCL falling edge. The engine answers through one open-drain pull-low enable for SDA.

It decodes the select byte and takes a one-byte word address. It keeps an internal address counter and serves current-address, random and sequential reads from a synchronous array read port with one cycle of latency. It forwards each accepted write byte to a page-write engine, together with its address. It signals a commit when a write transfer ends correctly. While that engine reports an internal write in progress, the slave stays off the bus, and a master can poll for completion by repeating the select byte.

Top module: `ee_twowire_slave`

## Requirements
- R1: A select byte is accepted only when its bits 7:4 equal 1010b and each of its bits 3:1 that does not carry an address bit equals the matching pin of `chip_en`. Bit 1 is compared with `chip_en[0]`, bit 2 with `chip_en[1]` and bit 3 with `chip_en[2]`. On a mismatch SDA stays released through the ninth clock and the engine waits for the next START.
- R2: On a select match, `sda_pull` is high from the SCL falling edge after the eighth bit until the SCL falling edge after the ninth bit.
- R3: In a write transfer the word-address byte is always acknowledged. It loads the low 8 counter bits. The select byte's bits 1, 2 and 3 load counter bits 8, 9 and 10 where the array needs them; with the default 512 bytes only bit 1 is address bit 8.
- R4: With `wr_lock` low, each write data byte is acknowledged and emitted as a one-cycle `wr_valid` pulse carrying the counter address and the byte.
- R5: With `wr_lock` high, write data bytes get NoAck and no `wr_valid` pulse is emitted. Reads are unaffected by `wr_lock`.
- R6: After each accepted data byte only the low 4 counter bits increment, so a page write wraps inside its 16-byte page.
- R7: `wr_commit` pulses one cycle after a STOP that arrives right after the acknowledge of an accepted data byte; a STOP anywhere else does not commit.
- R8: A random read is a write select, a word address, a repeated START and a read select; the first byte returned comes from that address.
- R9: Read bytes go out MSB first with the counter incremented after each byte. A master ACK continues with the next byte. A master NoAck releases SDA and returns the engine to idle. A current-address read starts at the counter.
- R10: During sequential reads the counter wraps from the last array address to 0.
- R11: While `wr_busy` is high the engine ignores all events and never pulls SDA, so a select byte gets NoAck.
- R12: A START in any state restarts select-byte reception without changing the address counter.
- R13: After reset SDA is released and `wr_valid`, `wr_commit` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | START or repeated START seen on the bus |
| stop_evt | input | 1 | STOP seen on the bus |
| bit_evt | input | 1 | SCL rising edge; `bit_val` holds the sampled SDA |
| bit_val | input | 1 | Sampled SDA level for `bit_evt` |
| scl_fall | input | 1 | SCL falling edge |
| chip_en | input | 3 | Strap pins compared with the select byte |
| wr_lock | input | 1 | High blocks writes to the array |
| wr_busy | input | 1 | Internal write cycle in progress |
| sda_pull | output | 1 | High pulls SDA low |
| wr_valid | output | 1 | One-cycle pulse for each accepted write byte |
| wr_addr | output | ADDR_W | Array address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | Start the internal write cycle |
| rd_en | output | 1 | Array read strobe |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | 8 | Array read data, valid one cycle after `rd_en` |

## Verification
A bad bit count or state shows on `sda_pull` within one SCL period: an acknowledge lands in the wrong slot, or a data bit drives where the master expects release. A corrupt address counter stays hidden until the next read byte, which then returns the wrong value or the wrong wrap point. The bench reads back every write and every wrap boundary to catch it. A lost or extra commit shows either as stale data on readback or as a select byte that is refused because the slave is busy.

// File: rtl/ee_twowire_pkg.sv
package ee_twowire_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } ew_state_e;

    // Byte-level control context: current phase, phase after the ACK slot,
    // bit position (0..7 data, 8 = ack drive, 9 = ack clock) and ack decision.
    typedef struct packed {
        ew_state_e  st;
        ew_state_e  nxt;
        logic [3:0] cnt;
        logic       ack;
    } ew_ctl_t;

    // Select hit: type nibble plus each strap bit not replaced by an address bit.
    function automatic logic sel_hit(input logic [7:0] sel, input logic [2:0] straps,
                                     input int hi_n);
        logic ok;
        ok = (sel[7:4] == DEV_TYPE);
        for (int i = 0; i < 3; i++) begin
            if (i >= hi_n && sel[i+1] != straps[i]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/ee_sel_decode.sv
module ee_sel_decode
    import ee_twowire_pkg::*;
#(
    parameter int HI_N = 1
) (
    input  logic [7:0] sel_byte,
    input  logic [2:0] straps,
    output logic       hit,
    output logic       is_read,
    output logic [2:0] hi_bits
);
    assign hit     = sel_hit(sel_byte, straps, HI_N);
    assign is_read = sel_byte[0];
    assign hi_bits = sel_byte[3:1];
endmodule

// File: rtl/ee_addr_ctr.sv
module ee_addr_ctr #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_hi,
    input  logic [2:0]        hi_in,
    input  logic              ld_lo,
    input  logic [7:0]        lo_in,
    input  logic              inc_seq,
    input  logic              inc_page,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] PMASK = ADDR_W'((1 << PAGE_W) - 1);

    logic [10:0]       ld_val;
    logic [ADDR_W-1:0] nxt;

    assign ld_val = {hi_in, lo_in};

    always_comb begin
        nxt = addr;
        if (inc_seq)  nxt = addr + 1'b1;
        if (inc_page) nxt = (addr & ~PMASK) | ((addr + 1'b1) & PMASK);
        for (int i = 0; i < ADDR_W; i++) begin
            if (i < 8 && ld_lo)  nxt[i] = ld_val[i];
            if (i >= 8 && ld_hi) nxt[i] = ld_val[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) addr <= '0;
        else     addr <= nxt;
    end

    // R10: full-range step from the top address lands on zero
    a_r10_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (inc_seq && !ld_lo && !ld_hi && addr == {ADDR_W{1'b1}}) |=> addr == '0);

    // R6: page step never disturbs the row bits
    a_r6_page_row_kept: assert property (@(posedge clk) disable iff (rst)
        (inc_page && !ld_lo && !ld_hi) |=>
        (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));
endmodule

// File: rtl/ee_twowire_slave.sv
module ee_twowire_slave
    import ee_twowire_pkg::*;
#(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 16,
    localparam int ADDR_W    = $clog2(MEM_BYTES),
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int HI_N      = (ADDR_W > 8) ? ADDR_W - 8 : 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              bit_evt,
    input  logic              bit_val,
    input  logic              scl_fall,
    input  logic [2:0]        chip_en,
    input  logic              wr_lock,
    input  logic              wr_busy,
    output logic              sda_pull,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    ew_ctl_t           ctl;
    logic [7:0]        shreg, tx, rx_byte;
    logic              rd_req, rd_cap, have_data;
    logic              hit, is_read;
    logic [2:0]        hi_bits;
    logic [ADDR_W-1:0] addr;
    logic              byte_done, ld_hi, ld_lo, inc_seq, inc_page;

    assign rx_byte   = {shreg[6:0], bit_val};
    assign byte_done = !wr_busy && !start_evt && !stop_evt && bit_evt &&
                       ctl.st != ST_IDLE && ctl.cnt == 4'd7;
    assign ld_hi     = byte_done && ctl.st == ST_DEV && hit;
    assign ld_lo     = byte_done && ctl.st == ST_ADDR;
    assign inc_page  = byte_done && ctl.st == ST_WDATA && !wr_lock;
    assign inc_seq   = byte_done && ctl.st == ST_RDATA;
    assign rd_en     = rd_req;
    assign rd_addr   = addr;

    ee_sel_decode #(.HI_N(HI_N)) sel_i (
        .sel_byte(rx_byte), .straps(chip_en),
        .hit(hit), .is_read(is_read), .hi_bits(hi_bits)
    );

    ee_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ctr_i (
        .clk(clk), .rst(rst),
        .ld_hi(ld_hi), .hi_in(hi_bits),
        .ld_lo(ld_lo), .lo_in(rx_byte),
        .inc_seq(inc_seq), .inc_page(inc_page),
        .addr(addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '{st: ST_IDLE, nxt: ST_IDLE, cnt: 4'd0, ack: 1'b0};
            shreg     <= '0;
            tx        <= '0;
            rd_req    <= 1'b0;
            rd_cap    <= 1'b0;
            have_data <= 1'b0;
            sda_pull  <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_valid  <= 1'b0;
            wr_commit <= 1'b0;
            rd_req    <= 1'b0;
            rd_cap    <= rd_req;
            if (rd_cap) tx <= rd_data;

            if (wr_busy) begin
                ctl.st   <= ST_IDLE;
                ctl.cnt  <= 4'd0;
                sda_pull <= 1'b0;
            end else if (start_evt) begin
                ctl.st   <= ST_DEV;
                ctl.cnt  <= 4'd0;
                sda_pull <= 1'b0;
            end else if (stop_evt) begin
                if (ctl.st == ST_WDATA && ctl.cnt == 4'd0 && have_data)
                    wr_commit <= 1'b1;
                ctl.st   <= ST_IDLE;
                ctl.cnt  <= 4'd0;
                sda_pull <= 1'b0;
            end else if (ctl.st != ST_IDLE) begin
                if (bit_evt) begin
                    if (ctl.cnt < 4'd7) begin
                        shreg   <= rx_byte;
                        ctl.cnt <= ctl.cnt + 4'd1;
                    end else if (ctl.cnt == 4'd7) begin
                        shreg   <= rx_byte;
                        ctl.cnt <= 4'd8;
                        case (ctl.st)
                            ST_DEV: begin
                                if (hit) begin
                                    ctl.ack   <= 1'b1;
                                    ctl.nxt   <= is_read ? ST_RDATA : ST_ADDR;
                                    rd_req    <= is_read;
                                    have_data <= 1'b0;
                                end else begin
                                    ctl.st   <= ST_IDLE;
                                    ctl.cnt  <= 4'd0;
                                    sda_pull <= 1'b0;
                                end
                            end
                            ST_ADDR: begin
                                ctl.ack <= 1'b1;
                                ctl.nxt <= ST_WDATA;
                            end
                            ST_WDATA: begin
                                ctl.ack <= !wr_lock;
                                ctl.nxt <= ST_WDATA;
                                if (!wr_lock) begin
                                    wr_valid  <= 1'b1;
                                    wr_addr   <= addr;
                                    wr_data   <= rx_byte;
                                    have_data <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end else if (ctl.cnt == 4'd8) begin
                        ctl.cnt <= 4'd9;
                        if (ctl.st == ST_RDATA) begin
                            if (bit_val) begin
                                ctl.st   <= ST_IDLE;
                                ctl.cnt  <= 4'd0;
                                sda_pull <= 1'b0;
                            end else begin
                                rd_req <= 1'b1;
                            end
                        end
                    end
                end else if (scl_fall) begin
                    if (ctl.st == ST_RDATA && ctl.cnt < 4'd8) begin
                        sda_pull <= ~tx[3'd7 - ctl.cnt[2:0]];
                    end else if (ctl.cnt == 4'd8) begin
                        sda_pull <= (ctl.st == ST_RDATA) ? 1'b0 : ctl.ack;
                    end else if (ctl.cnt == 4'd9) begin
                        ctl.cnt  <= 4'd0;
                        ctl.st   <= ctl.nxt;
                        sda_pull <= (ctl.nxt == ST_RDATA) ? ~tx[7] : 1'b0;
                    end
                end
            end
        end
    end

    // R11: a running internal write keeps the slave off the bus
    a_r11_busy_quiet: assert property (@(posedge clk) disable iff (rst)
        wr_busy |=> !sda_pull);

    // R5: no byte is handed on while the array is locked
    a_r5_lock_blocks_write: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !$past(wr_lock));

    // R7: a commit is always caused by a STOP
    a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(stop_evt));

    // R1: an idle slave never holds SDA
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        (ctl.st == ST_IDLE) |-> !sda_pull);

    // R8: each array read is a single strobe
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);
endmodule

// File: tb/ee_twowire_slave_tb_top.sv
module ee_twowire_slave_tb_top;
    localparam int NB = 512;
    localparam logic [2:0] CE = 3'b101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_evt = 0, stop_evt = 0, bit_evt = 0, bit_val = 0, scl_fall = 0;
    logic       wr_lock = 0;
    logic       busy;
    logic       sda_pull, wr_valid, wr_commit, rd_en;
    logic [8:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;

    logic [7:0] mem [NB];
    logic [7:0] exp_mem [NB];
    logic [8:0] stg_a [16];
    logic [7:0] stg_d [16];
    logic [4:0] stg_n;
    int         busy_cnt, commit_n, wv_n;
    int         n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;
    assign busy = (busy_cnt != 0);

    ee_twowire_slave dut_i (
        .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
        .bit_evt(bit_evt), .bit_val(bit_val), .scl_fall(scl_fall),
        .chip_en(CE), .wr_lock(wr_lock), .wr_busy(busy), .sda_pull(sda_pull),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    // Array and page-engine model
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NB; k++) mem[k] <= init_val(k);
            stg_n <= '0; busy_cnt <= 0; commit_n <= 0; wv_n <= 0; rd_data <= '0;
        end else begin
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if (start_evt) stg_n <= '0;
            if (wr_valid) begin
                wv_n <= wv_n + 1;
                if (stg_n < 5'd16) begin
                    stg_a[stg_n[3:0]] <= wr_addr;
                    stg_d[stg_n[3:0]] <= wr_data;
                    stg_n <= stg_n + 5'd1;
                end
            end
            if (wr_commit) begin
                for (int k = 0; k < 16; k++) if (k < int'(stg_n)) mem[stg_a[k]] <= stg_d[k];
                stg_n <= '0; busy_cnt <= 300; commit_n <= commit_n + 1;
            end
            if (rd_en) rd_data <= mem[rd_addr];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start_evt = 1; @(negedge clk) start_evt = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_stop();
        @(negedge clk) stop_evt = 1; @(negedge clk) stop_evt = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b);
        @(negedge clk) begin bit_val = b; bit_evt = 1; end
        @(negedge clk) bit_evt = 0;
        repeat (3) @(negedge clk);
        scl_fall = 1; @(negedge clk) scl_fall = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) bus_bit(d[i]);
        ack = sda_pull;
        bus_bit(1'b1);
    endtask

    task automatic get_byte(input logic more, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            d[i] = ~sda_pull;
            bus_bit(~sda_pull);
        end
        bus_bit(!more);
    endtask

    function automatic logic [7:0] sel(input logic a8, input logic rw);
        return {4'hA, CE[2], CE[1], a8, rw};
    endfunction

    task automatic wait_ready();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_seq(input logic [8:0] a, input int n, input logic [7:0] d0);
        logic ack;
        logic [8:0] wa;
        do_start();
        put_byte(sel(a[8], 1'b0), ack); chk("R2 write select ack", ack, 1);
        put_byte(a[7:0], ack);          chk("R3 word address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            put_byte(d0 + 8'(i * 17), ack);
            if (wr_lock) chk("R5 locked data NoAck", ack, 0);
            else         chk("R4 data ack", ack, 1);
            if (!wr_lock) begin
                wa = {a[8:4], 4'(a[3:0] + 4'(i))};
                exp_mem[wa] = d0 + 8'(i * 17);
            end
        end
        do_stop();
    endtask

    task automatic rd_seq(input logic [8:0] a, input int n, input string tag);
        logic ack;
        logic [7:0] d;
        do_start();
        put_byte(sel(a[8], 1'b0), ack);
        put_byte(a[7:0], ack);
        do_start();
        put_byte(sel(a[8], 1'b1), ack); chk({tag, " read select ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            get_byte(i < n - 1, d);
            chk(tag, d, exp_mem[9'(int'(a) + i)]);
        end
        chk("R9 SDA released after NoAck", sda_pull, 0);
        do_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int polls;
        int c0;
        for (int k = 0; k < NB; k++) exp_mem[k] = init_val(k);
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);
        // R13 reset state
        chk("R13 sda released", sda_pull, 0);
        chk("R13 no write pulse", wr_valid, 0);
        chk("R13 no commit", wr_commit, 0);
        chk("R13 no read strobe", rd_en, 0);

        // R1/R2 sweep of every select byte against straps 101
        for (int s = 0; s < 256; s++) begin
            logic e;
            do_start();
            put_byte(8'(s), ack);
            e = (s[7:4] == 4'hA) && (s[3] == CE[2]) && (s[2] == CE[1]);
            if (e) chk("R2 select ack on match", ack, 1);
            else   chk("R1 select NoAck on mismatch", ack, 0);
            do_stop();
        end

        // R6 page write wrapping inside the row, then R11 polling
        c0 = commit_n;
        wr_seq(9'h1FE, 3, 8'hC0);
        chk("R7 commit after STOP", commit_n - c0, 1);
        do_start();
        put_byte(sel(1'b0, 1'b0), ack);
        chk("R11 NoAck while busy", ack, 0);
        do_stop();
        polls = 1;
        while (!ack && polls < 50) begin
            do_start();
            put_byte(sel(1'b0, 1'b0), ack);
            do_stop();
            polls++;
        end
        chk("R11 ack once write finished", ack, 1);
        wait_ready();

        rd_seq(9'h1F0, 1, "R6 page wrap byte");
        // R10: crosses the top of the array; leaves counter at 0x002
        rd_seq(9'h1FD, 5, "R10 sequential wrap");

        // R9 current-address read
        do_start();
        put_byte(sel(1'b0, 1'b1), ack);
        get_byte(1'b0, d);
        chk("R9 current address read", d, exp_mem[2]);
        do_stop();

        // R12 START in the middle of the address byte keeps the counter (now 3)
        do_start();
        put_byte(sel(1'b0, 1'b0), ack);
        for (int i = 0; i < 4; i++) bus_bit(1'b1);
        do_start();
        put_byte(sel(1'b0, 1'b1), ack);
        chk("R12 select after abort", ack, 1);
        get_byte(1'b0, d);
        chk("R12 counter kept", d, exp_mem[3]);
        do_stop();

        // R5 lock: data refused, nothing forwarded, array unchanged
        wr_lock = 1;
        c0 = wv_n;
        wr_seq(9'h010, 2, 8'h5A);
        chk("R5 no write pulse when locked", wv_n - c0, 0);
        wait_ready();
        rd_seq(9'h010, 2, "R5 read while locked");
        wr_lock = 0;

        // R7 STOP inside a data byte does not commit
        c0 = commit_n;
        do_start();
        put_byte(sel(1'b0, 1'b0), ack);
        put_byte(8'h20, ack);
        put_byte(8'h99, ack);
        chk("R4 data ack before abort", ack, 1);
        for (int i = 0; i < 3; i++) bus_bit(1'b0);
        do_stop();
        chk("R7 no commit mid-byte", commit_n - c0, 0);
        wait_ready();
        rd_seq(9'h020, 1, "R7 array untouched");

        // R8 random read of a freshly written byte with address bit 8 set
        wr_seq(9'h133, 1, 8'h3C);
        wait_ready();
        rd_seq(9'h133, 1, "R8 random read");
        rd_seq(9'h0F0, 3, "R9 sequential read");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule